// File: doc/BRIEF.md
# MDIO Indirect-Address Management Controller

This block is the host side of a two-wire management link to PHY devices that use indirect register addressing. It holds a command register and a data register. A write to the command register with its start bit set launches one serial management frame on MDC/MDIO. While the frame is on the wire the start bit reads back as busy, and the block clears it when the last bit has been clocked out.

Reaching one PHY register takes two separate commands to the same port and device. The first is an address frame that loads the 16-bit register address into the PHY. The second is a write frame or a read frame. Write data is placed in the data register before the write command is issued. Read data is shifted in during the frame and appears in the upper half of the data register once the frame completes.

MDC comes from the system clock through a divider whose half period is set on a port. A half-period setting of zero selects divide-by-64.

Top module: `mdio_ix_ctrl`

## Requirements
- R1: After reset the busy bit is 0, the stored command fields are 0, both halves of the data register are 0, MDC is low and MDIO is not driven.
- R2: A command write with the start bit (cmd_wdata[28]) set while not busy sets busy on the next cycle. Busy clears by itself exactly 128*H cycles after that write, where H is the MDC half period in system clocks.
- R3: While busy, MDC is low for H cycles and then high for H cycles for each frame bit. H equals mdc_half, or 32 when mdc_half is 0. While not busy, MDC stays low.
- R4: The frame is sent MSB first in this order: 32 ones, start code 00, the 2-bit opcode cmd_wdata[27:26] (00 address, 01 write, 11 read), the port address cmd_wdata[25:21], the device address cmd_wdata[20:16], a 2-bit turnaround, and a 16-bit payload. Each bit is presented on MDIO from a falling edge of MDC and changes only while MDC is low.
- R5: Address frames drive turnaround 10 and payload cmd_wdata[15:0]. Write frames drive turnaround 10 and the lower half of the data register.
- R6: Opcodes with the upper bit set are reads. For a read, MDIO is released from the first turnaround bit (frame bit 46) to the end of the frame. The 16 payload bits are sampled from mdio_i on MDC rising edges, MSB first, and are placed in dat_rdata[31:16] when the frame ends.
- R7: A command write that arrives while busy is ignored: the stored fields and the frame in progress are unchanged.
- R8: A data-register write updates dat_rdata[15:0] on the next cycle. A data-register write made during a frame does not alter that frame.
- R9: dat_rdata[31:16] changes only at the end of a read frame. Address and write frames leave it unchanged.
- R10: A command write with the start bit clear while idle updates the stored fields (cmd_rdata[27:0]) without starting a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_half | input | 8 | MDC half period in system clocks; 0 selects 32 |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 29 | Command word: start[28], opcode[27:26], port[25:21], device[20:16], address[15:0] |
| cmd_rdata | output | 29 | Command readback with busy in bit 28 |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 16 | Write data for the lower half of the data register |
| dat_rdata | output | 32 | {read data, write data} |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench aims at the frame boundaries:
- The one-clock half period, where a divider with an off-by-one error would stretch or shorten every MDC phase.
- The default divide-by-64 selected by zero, where a design that took zero literally would hang or run too fast.
- The turnaround at bit 46, where releasing MDIO one bit late would cause contention with the PHY.
- The last payload bit, where missing its sample would shift the read value.

It also issues commands and data writes in the middle of a frame. A design without the busy guard would then corrupt the stored fields or restart the frame, and a design that did not latch the frame would change the write payload on the wire. Finally, it checks that address and write frames leave earlier read data in place.

// File: rtl/mdio_ix_pkg.sv
package mdio_ix_pkg;

  localparam int PORT_W    = 5;
  localparam int DEV_W     = 5;
  localparam int REG_W     = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PORT_W + DEV_W + 2 + REG_W;
  localparam int TA_POS    = PRE_LEN + 4 + PORT_W + DEV_W;
  localparam int PAY_POS   = TA_POS + 2;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RSVD  = 2'b10,
    OP_READ  = 2'b11
  } mdio_op_e;

  // field order gives the command word layout, MSB first
  typedef struct packed {
    mdio_op_e          op;
    logic [PORT_W-1:0] port;
    logic [DEV_W-1:0]  dev;
    logic [REG_W-1:0]  addr;
  } mdio_cmd_t;

  localparam int CMD_FLD_W = $bits(mdio_cmd_t);
  localparam int CMD_W     = CMD_FLD_W + 1;
  localparam int GO_BIT    = CMD_W - 1;

  function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_cmd_t c,
                                                       input logic [REG_W-1:0] wdata);
    logic [1:0]       ob;
    logic [1:0]       ta;
    logic [REG_W-1:0] pay;
    ob  = c.op;
    ta  = ob[1] ? 2'b11 : 2'b10;
    if (ob[1])               pay = '1;
    else if (ob == OP_WRITE) pay = wdata;
    else                     pay = c.addr;
    build_frame = {{PRE_LEN{1'b1}}, 2'b00, ob, c.port, c.dev, ta, pay};
  endfunction

endpackage

// File: rtl/mdio_ix_mdc_gen.sv
module mdio_ix_mdc_gen #(
  parameter int HALF_W   = 8,
  parameter int DEF_HALF = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              mdc_o,
  output logic              rise_o,
  output logic              fall_o
);

  logic [HALF_W-1:0] cnt_q, cnt_d, lim;
  logic              mdc_q, mdc_d, tick;

  always_comb begin
    lim   = (half_i == '0) ? HALF_W'(DEF_HALF - 1) : half_i - 1'b1;
    tick  = run_i && (cnt_q == lim);
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run_i) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;

endmodule

// File: rtl/mdio_ix_shifter.sv
module mdio_ix_shifter
  import mdio_ix_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  input  logic                 rd_type_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 mdio_i,
  output logic                 run_o,
  output logic                 done_o,
  output logic                 mdio_o,
  output logic                 mdio_oe_o,
  output logic [REG_W-1:0]     cap_o
);

  localparam int IDX_W = $clog2(FRAME_LEN);

  logic                 run_q, run_d, rdt_q, rdt_d, last;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [REG_W-1:0]     cap_q, cap_d;

  always_comb begin
    last  = (idx_q == IDX_W'(FRAME_LEN - 1));
    run_d = run_q;
    rdt_d = rdt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    cap_d = cap_q;
    if (!run_q) begin
      if (start_i) begin
        run_d = 1'b1;
        rdt_d = rd_type_i;
        idx_d = '0;
        sh_d  = frame_i;
        cap_d = '0;
      end
    end else begin
      if (rise_i && rdt_q && (idx_q >= IDX_W'(PAY_POS)))
        cap_d = {cap_q[REG_W-2:0], mdio_i};
      if (fall_i) begin
        if (last) begin
          run_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_LEN-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      rdt_q <= 1'b0;
      idx_q <= '0;
      sh_q  <= '1;
      cap_q <= '0;
    end else begin
      run_q <= run_d;
      rdt_q <= rdt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      cap_q <= cap_d;
    end
  end

  assign run_o     = run_q;
  assign done_o    = run_q && fall_i && last;
  assign mdio_o    = sh_q[FRAME_LEN-1];
  assign mdio_oe_o = run_q && !(rdt_q && (idx_q >= IDX_W'(TA_POS)));
  assign cap_o     = cap_q;

endmodule

// File: rtl/mdio_ix_ctrl.sv
module mdio_ix_ctrl
  import mdio_ix_pkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int DEF_HALF = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HALF_W-1:0]  mdc_half,
  input  logic               cmd_we,
  input  logic [CMD_W-1:0]   cmd_wdata,
  output logic [CMD_W-1:0]   cmd_rdata,
  input  logic               dat_we,
  input  logic [REG_W-1:0]   dat_wdata,
  output logic [2*REG_W-1:0] dat_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);

  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  mdio_cmd_t            cmd_q, cmd_d, cmd_new;
  logic [REG_W-1:0]     wdat_q, wdat_d, rdat_q, rdat_d, cap;
  logic [FRAME_LEN-1:0] frame;
  logic [1:0]           op_cur, op_new;
  logic                 busy, done, start, rise, fall;

  always_comb begin
    cmd_new = mdio_cmd_t'(cmd_wdata[CMD_FLD_W-1:0]);
    op_new  = cmd_new.op;
    op_cur  = cmd_q.op;
    start   = cmd_we && cmd_wdata[GO_BIT] && !busy;
    frame   = build_frame(cmd_new, wdat_q);
    cmd_d   = cmd_q;
    if (cmd_we && !busy) cmd_d = cmd_new;
    wdat_d  = wdat_q;
    if (dat_we) wdat_d = dat_wdata;
    rdat_d  = rdat_q;
    if (done && op_cur[1]) rdat_d = cap;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      cmd_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      wdat_q <= wdat_d;
      rdat_q <= rdat_d;
    end
  end

  mdio_ix_mdc_gen #(
    .HALF_W   (HALF_W),
    .DEF_HALF (DEF_HALF)
  ) u_mdc_gen (
    .clk    (clk),
    .rst_n  (rst_sync),
    .run_i  (busy),
    .half_i (mdc_half),
    .mdc_o  (mdc),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_ix_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_sync),
    .start_i   (start),
    .frame_i   (frame),
    .rd_type_i (op_new[1]),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .run_o     (busy),
    .done_o    (done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe),
    .cap_o     (cap)
  );

  assign cmd_rdata = {busy, cmd_q};
  assign dat_rdata = {rdat_q, wdat_q};

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (busy && cmd_we) |=> $stable(cmd_q));

  // R3
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !busy |-> !mdc);

  // R4
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (busy && $past(busy) && !$stable(mdio_o)) |-> !mdc);

  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    $fell(busy) |-> $past(mdc));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !busy |=> $stable(rdat_q));

endmodule

// File: tb/test_mdio_ix_ctrl.sv
`timescale 1ns/1ps
module test_mdio_ix_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  mdc_half;
  logic        cmd_we;
  logic [28:0] cmd_wdata;
  logic [28:0] cmd_rdata;
  logic        dat_we;
  logic [15:0] dat_wdata;
  logic [31:0] dat_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  always #2 clk = ~clk;

  mdio_ix_ctrl i_mdio_ix_ctrl (
    .clk(clk), .rst_n(rst_n), .mdc_half(mdc_half),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int vectors = 0;
  int fails   = 0;
  bit fin     = 1'b0;

  // behavioural reference state
  bit          m_busy;
  int          m_e, m_h;
  bit          m_rd;
  logic [63:0] m_frame;
  logic [27:0] m_cmd;
  logic [15:0] m_wdat, m_rdat, m_phy;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] mk_frame(input logic [27:0] c, input logic [15:0] w);
    logic [1:0]  op;
    logic [15:0] pay;
    op = c[27:26];
    if (op[1])            pay = 16'hFFFF;
    else if (op == 2'b01) pay = w;
    else                  pay = c[15:0];
    return {32'hFFFF_FFFF, 2'b00, op, c[25:21], c[20:16], (op[1] ? 2'b11 : 2'b10), pay};
  endfunction

  always @(posedge clk) begin
    bit was;
    if (!rst_n) begin
      m_busy = 0; m_e = 0; m_h = 1; m_rd = 0;
      m_frame = '1; m_cmd = '0; m_wdat = '0; m_rdat = '0;
    end else begin
      was = m_busy;
      if (was) begin
        m_e++;
        if (m_e == 128 * m_h) begin
          m_busy = 0;
          if (m_rd) m_rdat = m_phy;
        end
      end
      if (!was && cmd_we) begin
        m_cmd = cmd_wdata[27:0];
        if (cmd_wdata[28]) begin
          m_busy  = 1;
          m_e     = 0;
          m_h     = (mdc_half == 0) ? 32 : int'(mdc_half);
          m_rd    = cmd_wdata[27];
          m_frame = mk_frame(cmd_wdata[27:0], m_wdat);
        end
      end
      if (dat_we) m_wdat = dat_wdata;
    end
  end

  always @(negedge clk) begin
    int b;
    bit emdc, eoe;
    b    = m_busy ? m_e / (2 * m_h) : 0;
    emdc = m_busy && ((m_e % (2 * m_h)) >= m_h);
    eoe  = m_busy && !(m_rd && b >= 46);
    if (rst_n && !fin) begin
      chk({31'd0, cmd_rdata[28]}, {31'd0, m_busy}, "R2 busy");
      chk({31'd0, mdc}, {31'd0, emdc}, "R3 mdc");
      chk({31'd0, mdio_oe}, {31'd0, eoe}, "R6 mdio_oe");
      if (eoe) chk({31'd0, mdio_o}, {31'd0, m_frame[63 - b]}, "R4 R5 mdio_o");
      chk({4'd0, cmd_rdata[27:0]}, {4'd0, m_cmd}, "R7 R10 cmd fields");
      chk(dat_rdata, {m_rdat, m_wdat}, "R6 R8 R9 data register");
    end
    mdio_i = (m_busy && m_rd && b >= 48) ? m_phy[63 - b] : 1'b1;
  end

  task automatic wr_cmd(input bit go, input logic [1:0] op, input logic [4:0] p,
                        input logic [4:0] d, input logic [15:0] a);
    @(negedge clk);
    cmd_we = 1; cmd_wdata = {go, op, p, d, a};
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic wr_dat(input logic [15:0] v);
    @(negedge clk);
    dat_we = 1; dat_wdata = v;
    @(negedge clk);
    dat_we = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 0; mdc_half = 8'd2; cmd_we = 0; cmd_wdata = '0;
    dat_we = 0; dat_wdata = '0; m_phy = 16'h0; mdio_i = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({3'd0, cmd_rdata}, 32'd0, "R1 cmd_rdata");
    chk(dat_rdata, 32'd0, "R1 dat_rdata");
    chk({30'd0, mdc, mdio_oe}, 32'd0, "R1 mdc/oe");

    // R5 address frame, R7 ignored command, R8 data write mid-frame
    wr_dat(16'hA5C3);
    wr_cmd(1, 2'b00, 5'h03, 5'h01, 16'h0020);
    repeat (20) @(negedge clk);
    wr_cmd(1, 2'b11, 5'h1F, 5'h1E, 16'hDEAD);
    wr_dat(16'h1234);
    wait_idle();
    chk({4'd0, cmd_rdata[27:0]}, {4'd0, 2'b00, 5'h03, 5'h01, 16'h0020}, "R7 fields kept");

    // R5 write frame, R8 latch
    wr_cmd(1, 2'b01, 5'h03, 5'h01, 16'h0000);
    repeat (200) @(negedge clk);
    wr_dat(16'hFFFF);
    wait_idle();
    chk(dat_rdata[15:0], 16'hFFFF, "R8 lower half");

    // R6 read with H=3
    mdc_half = 8'd3; m_phy = 16'hBEEF;
    wr_cmd(1, 2'b11, 5'h03, 5'h01, 16'h0000);
    wait_idle();
    chk(dat_rdata[31:16], 16'hBEEF, "R6 read data");

    // R10 stored without start
    wr_cmd(0, 2'b01, 5'h11, 5'h07, 16'h4321);
    repeat (10) @(negedge clk);
    chk({31'd0, cmd_rdata[28]}, 32'd0, "R10 no start");

    // R3 H=1 boundary read, then R9 unaffected by address frame
    mdc_half = 8'd1; m_phy = 16'h8001;
    wr_cmd(1, 2'b11, 5'h00, 5'h1F, 16'h0000);
    wait_idle();
    chk(dat_rdata[31:16], 16'h8001, "R6 read H=1");
    wr_cmd(1, 2'b00, 5'h1F, 5'h00, 16'hFFFE);
    wait_idle();
    chk(dat_rdata[31:16], 16'h8001, "R9 kept after address frame");

    // R3 default divider
    mdc_half = 8'd0; m_phy = 16'h5A0F;
    wr_cmd(1, 2'b11, 5'h15, 5'h0A, 16'h0000);
    wait_idle();
    chk(dat_rdata[31:16], 16'h5A0F, "R3 default divide read");

    // R2 odd half period write
    mdc_half = 8'd7;
    wr_dat(16'h0F0F);
    wr_cmd(1, 2'b01, 5'h0A, 5'h15, 16'h0000);
    wait_idle();

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule